// File: doc/BRIEF.md
# Floating Result Writeback and Fault Unit

This block is the last stage of a floating-point arithmetic pipe. Each accepted transfer carries a candidate result word, an operation class, four exception flags (reserved operand, underflow, overflow, divide-by-zero) and the software underflow-fault enable. From these the block decides whether the destination register is written and with which value. It updates the four condition codes (negative, zero, overflow, carry). When the operation cannot complete, it raises one fault with a two-bit cause code.

Underflow depends on the enable bit. When the bit is set, underflow is a fault and the destination is left alone. When it is clear, zero is written quietly. A plain move keeps the carry it found, while every other class clears it. Integer-side logic shares the same status word and can load the flags through a separate port between floating writebacks.

All outputs are registered. A transfer accepted on one clock edge produces a single-cycle result strobe on the next edge.

Top module: `fwb_unit`

## Requirements
- R1: A transfer is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. `out_valid_o` is high for exactly the one cycle after that edge and low otherwise. `in_ready_o` is low in reset and high after it.
- R2: A fault is taken when reserved operand, divide-by-zero or overflow is flagged, or when underflow is flagged with `fu_en_i` = 1. A faulting result has `fault_o` = 1 and `wr_en_o` = 0.
- R3: The cause codes are 00 reserved operand, 01 underflow, 10 overflow and 11 divide-by-zero. When several flags are set, the cause is chosen in the order reserved operand, then divide-by-zero, then overflow, then underflow.
- R4: Underflow with `fu_en_i` = 0, and no other flag set, raises no fault. The value written, and the value the flags are taken from, is all zeros.
- R5: On a non-faulting result, N equals bit DATA_W-1 of the written value. Z is 1 exactly when every bit of that value is 0.
- R6: V is 0 after every non-faulting result.
- R7: Operation class codes are 0 add, 1 subtract, 2 multiply, 3 divide, 4 move, 5 negate, 6 test and 7 other arithmetic. Class 4 leaves C at its previous value on a non-faulting result. Every other class clears C.
- R8: Class 6 (test) never asserts `wr_en_o`. It still updates the flags from its source value.
- R9: A faulting result leaves all four flags unchanged.
- R10: `cc_ld_i` = 1 loads `cc_ld_val_i` into the flags on that edge. The load is dropped when a non-faulting result updates the flags on the same edge. `wr_data_o` is 0 whenever `wr_en_o` is 0.
- R11: Reset clears the flags to 0 and deasserts `out_valid_o`, `wr_en_o` and `fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Candidate result present |
| in_ready_o | output | 1 | Block can accept a transfer |
| op_i | input | 3 | Operation class |
| res_i | input | DATA_W | Candidate result, sign in MSB |
| rsv_i | input | 1 | Reserved operand flagged |
| unf_i | input | 1 | Underflow flagged |
| ovf_i | input | 1 | Overflow flagged |
| dvz_i | input | 1 | Divide by zero flagged |
| fu_en_i | input | 1 | Underflow fault enable |
| cc_ld_i | input | 1 | Load flags from integer side |
| cc_ld_val_i | input | 4 | Flag load value {N,Z,V,C} |
| out_valid_o | output | 1 | Result strobe, one cycle |
| wr_en_o | output | 1 | Destination write enable |
| wr_data_o | output | DATA_W | Destination write value |
| fault_o | output | 1 | Fault raised |
| cause_o | output | 2 | Fault cause code |
| cc_o | output | 4 | Flags {N,Z,V,C} |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe that follows each accepted transfer;
- that a fault never comes with a write;
- that a write only happens under the strobe;
- that V is clear after a completed result;
- that the flags are frozen across a fault;
- that a quiet underflow writes zero.

The cause priority and the exact N and Z values need the bench's sweep. So do the move-class carry keep and the test-class suppression. The sweep crosses every class with every flag combination, both enable settings, and signed, zero and negative-zero words, starting from preloaded flag patterns. Only directed scenarios can show the collision between a flag load and a floating update.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_DIV = 3'd3,
    OP_MOV = 3'd4, OP_NEG = 3'd5, OP_TST = 3'd6, OP_ARI = 3'd7
  } fwb_op_e;

  typedef enum logic [1:0] {
    FC_RSV = 2'b00, FC_UNF = 2'b01, FC_OVF = 2'b10, FC_DVZ = 2'b11
  } fwb_cause_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } fwb_cc_t;

  localparam int unsigned CC_W = $bits(fwb_cc_t);
endpackage

// File: rtl/fwb_fault_sel.sv
module fwb_fault_sel
  import fwb_pkg::*;
(
  input  logic       rsv_i,
  input  logic       unf_i,
  input  logic       ovf_i,
  input  logic       dvz_i,
  input  logic       fu_en_i,
  output logic       fault_o,
  output fwb_cause_e cause_o
);
  logic unf_fault;
  assign unf_fault = unf_i & fu_en_i;
  assign fault_o   = rsv_i | dvz_i | ovf_i | unf_fault;

  // fixed priority: reserved > div0 > overflow > underflow
  always_comb begin
    if (rsv_i)      cause_o = FC_RSV;
    else if (dvz_i) cause_o = FC_DVZ;
    else if (ovf_i) cause_o = FC_OVF;
    else            cause_o = FC_UNF;
  end
endmodule

// File: rtl/fwb_result_sel.sv
module fwb_result_sel
  import fwb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwb_op_e           op_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              unf_i,
  input  logic              fault_i,
  output logic [DATA_W-1:0] value_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);
  // quiet underflow substitutes zero
  assign value_o   = unf_i ? '0 : res_i;
  assign wr_en_o   = !fault_i && (op_i != OP_TST);
  assign wr_data_o = wr_en_o ? value_o : '0;
endmodule

// File: rtl/fwb_cc_unit.sv
module fwb_cc_unit
  import fwb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  fwb_op_e           op_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              ld_i,
  input  fwb_cc_t           ld_val_i,
  output fwb_cc_t           cc_o
);
  fwb_cc_t cc_q, cc_d;

  always_comb begin
    cc_d = cc_q;
    if (upd_i) begin
      cc_d.n = value_i[DATA_W-1];
      cc_d.z = (value_i == '0);
      cc_d.v = 1'b0;
      cc_d.c = (op_i == OP_MOV) ? cc_q.c : 1'b0;
    end else if (ld_i) begin
      cc_d = ld_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cc_q <= '0;
    else         cc_q <= cc_d;
  end

  assign cc_o = cc_q;
endmodule

// File: rtl/fwb_unit.sv
module fwb_unit
  import fwb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              rsv_i,
  input  logic              unf_i,
  input  logic              ovf_i,
  input  logic              dvz_i,
  input  logic              fu_en_i,
  input  logic              cc_ld_i,
  input  logic [3:0]        cc_ld_val_i,
  output logic              out_valid_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              fault_o,
  output logic [1:0]        cause_o,
  output logic [3:0]        cc_o
);
  fwb_op_e           op;
  logic              accept, fault_c, wr_en_c;
  fwb_cause_e        cause_c;
  logic [DATA_W-1:0] value_c, wr_data_c;
  fwb_cc_t           cc;

  logic              ready_q, valid_q, wr_en_q, fault_q;
  logic [1:0]        cause_q;
  logic [DATA_W-1:0] wr_data_q;

  assign op     = fwb_op_e'(op_i);
  assign accept = in_valid_i && ready_q;

  fwb_fault_sel u_fault (
    .rsv_i   (rsv_i),
    .unf_i   (unf_i),
    .ovf_i   (ovf_i),
    .dvz_i   (dvz_i),
    .fu_en_i (fu_en_i),
    .fault_o (fault_c),
    .cause_o (cause_c)
  );

  fwb_result_sel #(.DATA_W(DATA_W)) u_res (
    .op_i      (op),
    .res_i     (res_i),
    .unf_i     (unf_i),
    .fault_i   (fault_c),
    .value_o   (value_c),
    .wr_en_o   (wr_en_c),
    .wr_data_o (wr_data_c)
  );

  fwb_cc_unit #(.DATA_W(DATA_W)) u_cc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (accept && !fault_c),
    .op_i     (op),
    .value_i  (value_c),
    .ld_i     (cc_ld_i),
    .ld_val_i (fwb_cc_t'(cc_ld_val_i)),
    .cc_o     (cc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q   <= 1'b0;
      valid_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      fault_q   <= 1'b0;
      cause_q   <= '0;
      wr_data_q <= '0;
    end else begin
      ready_q   <= 1'b1;
      valid_q   <= accept;
      wr_en_q   <= accept && wr_en_c;
      fault_q   <= accept && fault_c;
      cause_q   <= accept ? cause_c : 2'b00;
      wr_data_q <= accept ? wr_data_c : '0;
    end
  end

  assign in_ready_o  = ready_q;
  assign out_valid_o = valid_q;
  assign wr_en_o     = wr_en_q;
  assign wr_data_o   = wr_data_q;
  assign fault_o     = fault_q;
  assign cause_o     = cause_q;
  assign cc_o        = cc;

  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);  // R1
  AST_NO_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !out_valid_o);  // R1
  AST_FAULT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !wr_en_o);  // R2
  AST_WRITE_UNDER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || fault_o) |-> out_valid_o);  // R1
  AST_V_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !fault_o) |-> !cc_o[1]);  // R6
  AST_CC_FROZEN_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && fault_o && !$past(cc_ld_i)) |-> (cc_o == $past(cc_o)));  // R9
  AST_QUIET_UNF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && unf_i && !fu_en_i && !rsv_i && !ovf_i && !dvz_i)
      |=> (!fault_o && wr_data_o == '0));  // R4
endmodule

// File: tb/fwb_unit_bench.sv
module fwb_unit_bench;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ready;
  logic [2:0]    op = '0;
  logic [DW-1:0] res = '0;
  logic          rsv = 0, unf = 0, ovf = 0, dvz = 0, fu_en = 0;
  logic          cc_ld = 0;
  logic [3:0]    cc_ld_val = '0;
  logic          out_valid, wr_en, fault;
  logic [DW-1:0] wr_data;
  logic [1:0]    cause;
  logic [3:0]    cc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fwb_unit #(.DATA_W(DW)) u_fwb_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .res_i(res), .rsv_i(rsv), .unf_i(unf), .ovf_i(ovf), .dvz_i(dvz),
    .fu_en_i(fu_en), .cc_ld_i(cc_ld), .cc_ld_val_i(cc_ld_val),
    .out_valid_o(out_valid), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .fault_o(fault), .cause_o(cause), .cc_o(cc)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    case (k)
      0: return '0;
      1: return 32'h4080_0000;
      2: return 32'hC120_0000;
      default: return 32'h8000_0000;
    endcase
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic          e_fault, e_wr;
    logic [1:0]    e_cause;
    logic [DW-1:0] e_val;
    logic [3:0]    e_cc, p;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cc", DW'(cc), '0);
    chk("R11 valid", DW'(out_valid), '0);
    chk("R11 wr_en", DW'(wr_en), '0);
    chk("R11 fault", DW'(fault), '0);
    chk("R1 ready in reset", DW'(in_ready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", DW'(in_ready), 1);

    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 16; f++)
        for (int u = 0; u < 2; u++)
          for (int d = 0; d < 4; d++) begin
            p = 4'((o * 5 + f + u * 3 + d * 7) % 16);
            cc_ld = 1'b1; cc_ld_val = p;
            @(negedge clk);
            chk("R10 load", DW'(cc), DW'(p));
            cc_ld = 1'b0;
            in_valid = 1'b1; op = 3'(o); res = pat(d);
            rsv = f[0]; unf = f[1]; ovf = f[2]; dvz = f[3]; fu_en = u[0];
            e_fault = rsv | dvz | ovf | (unf & fu_en);
            e_cause = rsv ? 2'b00 : dvz ? 2'b11 : ovf ? 2'b10 : 2'b01;
            e_val   = unf ? '0 : res;
            e_wr    = !e_fault && (o != 6);
            if (e_fault) e_cc = p;
            else e_cc = {e_val[DW-1], e_val == '0, 1'b0, (o == 4) ? p[0] : 1'b0};
            @(negedge clk);
            in_valid = 1'b0;
            chk("R1 strobe", DW'(out_valid), 1);
            chk("R2 fault", DW'(fault), DW'(e_fault));
            chk(o == 6 ? "R8 test write" : "R2 write", DW'(wr_en), DW'(e_wr));
            chk(unf ? "R4 data" : "R10 data", wr_data, e_wr ? e_val : '0);
            if (e_fault) begin
              chk("R3 cause", DW'(cause), DW'(e_cause));
              chk("R9 cc hold", DW'(cc), DW'(e_cc));
            end else begin
              chk("R5 N", DW'(cc[3]), DW'(e_cc[3]));
              chk("R5 Z", DW'(cc[2]), DW'(e_cc[2]));
              chk("R6 V", DW'(cc[1]), 0);
              chk("R7 C", DW'(cc[0]), DW'(e_cc[0]));
            end
            @(negedge clk);
            chk("R1 single cycle", DW'(out_valid), 0);
            chk("R9 idle hold", DW'(cc), DW'(e_cc));
          end

    // R10 collision: non-faulting update wins over load
    rsv = 0; unf = 0; ovf = 0; dvz = 0; fu_en = 0;
    in_valid = 1; op = 3'd0; res = 32'h4000_0000; cc_ld = 1; cc_ld_val = 4'hF;
    @(negedge clk);
    in_valid = 0; cc_ld = 0;
    chk("R10 update beats load", DW'(cc), 32'h0);
    // R10 collision with fault: load applies
    in_valid = 1; ovf = 1; cc_ld = 1; cc_ld_val = 4'hB;
    @(negedge clk);
    in_valid = 0; cc_ld = 0; ovf = 0;
    chk("R10 load beside fault", DW'(cc), 32'hB);
    chk("R2 overflow fault", DW'(fault), 1);
    // R1 back-to-back strobes
    in_valid = 1; op = 3'd4; res = 32'h8000_0001;
    @(negedge clk);
    chk("R1 b2b first", DW'(out_valid), 1);
    chk("R7 move keeps C", DW'(cc), 32'h9);
    @(negedge clk);
    in_valid = 0;
    chk("R1 b2b second", DW'(out_valid), 1);
    @(negedge clk);
    chk("R1 b2b end", DW'(out_valid), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule